// File: doc/BRIEF.md
# Multi-Input Wakeup Edge Detector

This block watches a group of input pins (eight by default) and records
qualifying transitions on them. Each pin has an enable bit and a polarity bit.
Polarity 0 makes a low-to-high transition qualify. Polarity 1 makes a
high-to-low transition qualify. When an enabled pin makes a qualifying
transition, a pending flag is latched for that pin. The enabled pending flags
are ORed together to form a wakeup request, which lets a power controller bring
the device out of a low-power state. The same request, gated by a global
interrupt-enable input, becomes a shared interrupt request while the device is
running.

Software reaches the block through a small register bus. The bus carries a
2-bit register select, a write strobe, write data, and combinational read data.
There are three byte-wide registers: the enable mask, the polarity mask and the
pending flags. The pending flags are not reset, so software clears them once at
start-up.

Changing a pin's polarity while the pin is low makes the block see a transition
that never happened. The intended procedure is therefore to change polarity
first and clear the pending flags afterwards.

Top module: `wkup_detect`

## Requirements
- R1: After reset the enable mask (select 0) and the polarity mask (select 1) read as zero, and `wake_o` and `irq_o` are low.
- R2: A write to select 0 or select 1 updates that mask and reads back unchanged. Select 3 always reads zero, and a write to it changes no register.
- R3: With polarity bit 0, a low-to-high change on an enabled pin sets its pending bit (select 2, bit position equal to the pin index). The bit reads as set after the third rising clock edge that follows the pin change, and not before.
- R4: With polarity bit 1, a high-to-low change sets the pending bit, and a low-to-high change leaves it clear.
- R5: A transition on a pin whose enable bit is 0 does not set its pending bit.
- R6: Writing select 2 clears each pending bit whose write-data bit is 0. Bits written as 1 keep their value.
- R7: When a qualifying transition and a clearing write hit the same pending bit on the same clock edge, the bit ends up set.
- R8: `wake_o` is high exactly when some pin has both its pending bit and its enable bit set. Clearing the enable bit drops `wake_o` and keeps the pending bit.
- R9: `irq_o` equals `wake_o` when `glob_int_en` is 1, and is low when `glob_int_en` is 0.
- R10: Setting a pin's polarity bit from 0 to 1 while that enabled pin is low sets its pending bit even though the pin does not change.
- R11: Every pin is detected on its own. Several pins changing together, each with its own polarity, set exactly the matching pending bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Monitored pins, asynchronous to clk |
| bus_addr | input | 2 | Register select: 0 enable, 1 polarity, 2 pending, 3 reserved |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for the selected register |
| glob_int_en | input | 1 | Global interrupt enable |
| wake_o | output | 1 | Wakeup request |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench uses the default parameters: NPINS = 8 and SYNC_STAGES = 2. The
two-stage depth fixes the pending latency at three clock edges. The bench
relies on that latency twice: to check that the flag is not set early, and to
place a clearing write on exactly the edge where a set lands. Eight pins are
enough to drive mixed polarities at once. They also allow partial write-0 clear
patterns and the false transition caused by a polarity change on a single pin.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_POL  = 2'd1,
    REG_PEND = 2'd2,
    REG_RSVD = 2'd3
  } wk_reg_e;

  localparam int ADDR_W = 2;
endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wkup_edge.sv
module wkup_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] edge_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic norm;
    logic norm_q;

    // polarity folded in before the history flop
    assign norm = lvl_i[g] ^ pol_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) norm_q <= 1'b0;
      else        norm_q <= norm;
    end

    assign edge_o[g] = norm & ~norm_q;
  end
endmodule

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  set_vec,
  output logic [WIDTH-1:0]  en_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic [WIDTH-1:0]  pend_q,
  output logic [WIDTH-1:0]  rdata
);
  logic             wr_en;
  logic             wr_pol;
  logic             wr_pend;
  logic [WIDTH-1:0] en_d;
  logic [WIDTH-1:0] pol_d;
  logic [WIDTH-1:0] pend_d;
  wk_reg_e          sel;

  assign sel     = wk_reg_e'(bus_addr);
  assign wr_en   = bus_wr && (sel == REG_EN);
  assign wr_pol  = bus_wr && (sel == REG_POL);
  assign wr_pend = bus_wr && (sel == REG_PEND);

  always_comb begin
    en_d   = wr_en  ? bus_wdata : en_q;
    pol_d  = wr_pol ? bus_wdata : pol_q;
    pend_d = wr_pend ? (pend_q & bus_wdata) : pend_q;
    pend_d = pend_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      en_q  <= en_d;
      pol_q <= pol_d;
    end
  end

  // pending flags carry no reset by design
  always_ff @(posedge clk) begin
    pend_q <= pend_d;
  end

  always_comb begin
    unique case (sel)
      REG_EN:   rdata = en_q;
      REG_POL:  rdata = pol_q;
      REG_PEND: rdata = pend_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wkup_detect.sv
module wkup_detect
  import wkup_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic              glob_int_en,
  output logic              wake_o,
  output logic              irq_o
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] edge_vec;
  logic [NPINS-1:0] set_vec;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] pend_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  wkup_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  wkup_edge #(.WIDTH(NPINS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (pin_sync),
    .pol_i  (pol_q),
    .edge_o (edge_vec)
  );

  assign set_vec = edge_vec & en_q;

  wkup_regs #(.WIDTH(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .set_vec   (set_vec),
    .en_q      (en_q),
    .pol_q     (pol_q),
    .pend_q    (pend_q),
    .rdata     (bus_rdata)
  );

  assign wake_o = |(pend_q & en_q);
  assign irq_o  = wake_o & glob_int_en;
endmodule

// File: rtl/wkup_detect_chk.sv
module wkup_detect_chk
  import wkup_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  pend_q,
  input logic [NPINS-1:0]  set_vec,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              wake_o,
  input logic              irq_o
);
  assert_en_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0));

  assert_no_unenabled_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  assert_zero_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == REG_PEND)) |=>
      ((pend_q & ~$past(bus_wdata) & ~$past(set_vec)) == '0));

  assert_set_dominates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~pend_q) == '0));

  assert_irq_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_o |-> !irq_o);
endmodule

bind wkup_detect wkup_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .pend_q    (pend_q),
  .set_vec   (set_vec),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .wake_o    (wake_o),
  .irq_o     (irq_o)
);

// File: tb/tb_wkup_detect.sv
module tb_wkup_detect;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_i;
  logic [1:0]   bus_addr;
  logic         bus_wr;
  logic [N-1:0] bus_wdata;
  logic [N-1:0] bus_rdata;
  logic         glob_int_en;
  logic         wake_o;
  logic         irq_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  wkup_detect #(.NPINS(N), .SYNC_STAGES(2)) dut (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_i),
    .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .glob_int_en (glob_int_en),
    .wake_o (wake_o), .irq_o (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd0, '0);
    wr(2'd1, '0);
    pin_i = '0;
    idle(5);
    wr(2'd2, '0);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(2'd0, v); chk("R1 enable", v, 0);
    rd(2'd1, v); chk("R1 polarity", v, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_regs();
    logic [N-1:0] v;
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R2 enable rb", v, 8'h5A);
    wr(2'd1, 8'hC3); rd(2'd1, v); chk("R2 polarity rb", v, 8'hC3);
    rd(2'd3, v); chk("R2 rsvd read", v, 0);
    wr(2'd3, 8'hFF);
    rd(2'd0, v); chk("R2 enable after rsvd wr", v, 8'h5A);
    rd(2'd1, v); chk("R2 polarity after rsvd wr", v, 8'hC3);
    rd(2'd3, v); chk("R2 rsvd read after wr", v, 0);
    wr(2'd0, '0);
    wr(2'd1, '0);
  endtask

  task automatic t_rise();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'h01);
    @(negedge clk); pin_i[0] = 1'b1;
    idle(2); rd(2'd2, v); chk("R3 not before third edge", v, 0);
    idle(1); rd(2'd2, v); chk("R3 set on third edge", v, 8'h01);
    chk("R3 wake", wake_o, 1);
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    quiesce();
    pin_i[1] = 1'b1; idle(4);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h02);
    idle(3);
    wr(2'd2, '0);
    @(negedge clk); pin_i[1] = 1'b0;
    idle(4); rd(2'd2, v); chk("R4 falling sets", v, 8'h02);
    wr(2'd2, '0);
    @(negedge clk); pin_i[1] = 1'b1;
    idle(5); rd(2'd2, v); chk("R4 rising ignored", v, 0);
  endtask

  task automatic t_disabled();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'hFB);
    @(negedge clk); pin_i[2] = 1'b1;
    idle(5); rd(2'd2, v); chk("R5 disabled pin", v, 0);
    chk("R5 wake", wake_o, 0);
  endtask

  task automatic t_clear();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'h09);
    @(negedge clk); pin_i = 8'h09;
    idle(5); rd(2'd2, v); chk("R6 two set", v, 8'h09);
    wr(2'd2, 8'hF7);
    rd(2'd2, v); chk("R6 partial clear", v, 8'h01);
    wr(2'd2, 8'hFE);
    rd(2'd2, v); chk("R6 full clear", v, 0);
  endtask

  task automatic t_setwins();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'h10);
    @(negedge clk); pin_i[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = '0; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(2'd2, v); chk("R7 set wins", v, 8'h10);
  endtask

  task automatic t_wake();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'h20);
    @(negedge clk); pin_i[5] = 1'b1;
    idle(4); chk("R8 wake high", wake_o, 1);
    wr(2'd0, '0);
    chk("R8 wake drops", wake_o, 0);
    rd(2'd2, v); chk("R8 pending kept", v, 8'h20);
    wr(2'd0, 8'h20);
    chk("R8 wake back", wake_o, 1);
  endtask

  task automatic t_irq();
    glob_int_en = 1'b0; #1;
    chk("R9 irq gated", irq_o, 0);
    glob_int_en = 1'b1; #1;
    chk("R9 irq follows", irq_o, 1);
    wr(2'd2, '0);
    chk("R9 irq low no wake", irq_o, 0);
  endtask

  task automatic t_spurious();
    logic [N-1:0] v;
    quiesce();
    wr(2'd0, 8'h40);
    idle(2);
    rd(2'd2, v); chk("R10 clean before", v, 0);
    wr(2'd1, 8'h40);
    idle(3); rd(2'd2, v); chk("R10 false edge", v, 8'h40);
  endtask

  task automatic t_multi();
    logic [N-1:0] v;
    quiesce();
    pin_i = 8'hF0; idle(4);
    wr(2'd1, 8'hF0);
    idle(3);
    wr(2'd2, '0);
    wr(2'd0, 8'hFF);
    @(negedge clk); pin_i = 8'h0F;
    idle(5); rd(2'd2, v); chk("R11 all eight", v, 8'hFF);
    wr(2'd2, '0);
    @(negedge clk); pin_i = 8'h00;
    idle(5); rd(2'd2, v); chk("R11 none qualify", v, 0);
    @(negedge clk); pin_i = 8'hA5;
    idle(5); rd(2'd2, v); chk("R11 mixed", v, 8'h05);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_i = '0; bus_addr = '0; bus_wr = 1'b0;
    bus_wdata = '0; glob_int_en = 1'b1;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_disabled();
    t_clear();
    t_setwins();
    t_wake();
    t_irq();
    t_spurious();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule